// File: doc/BRIEF.md
# Multi-mode interval counter channel

This block is a single down-counting channel of a programmable interval timer. A register interface elsewhere supplies a mode code and an initial count. The channel then counts down once per asserted `tick_en`. It shows the live count on `count_out` and drives a mode-dependent level on `out_level`. The `gate` input behaves differently by mode:

- In the periodic and one-shot modes, a rising edge on `gate` reloads the count and restarts it.
- In the interrupt-on-terminal-count and software-strobe modes, the level of `gate` only pauses or resumes counting.

Control is a two-state machine:

- `ST_ARMED`: a mode has been written and no count has been loaded yet.
- `ST_COUNTING`: the channel responds to ticks and gate events.

It has three named transitions:

- ARM_TO_COUNT: a count load while in `ST_ARMED`.
- COUNT_TO_ARM: a mode write without a load while in `ST_COUNTING`.
- STAY: every other cycle.

A mode write keeps the machine in `ST_ARMED` or returns it there. A count load always ends in `ST_COUNTING`.

Mode codes on `mode_code` are:

| Code | Mode |
|------|------|
| 0 | interrupt on terminal count |
| 1 | retriggerable one-shot |
| 2 | rate generator |
| 3 | square wave |
| 4 | software strobe |
| 5 | hardware strobe |
| 6 | alias of 2 |
| 7 | alias of 3 |

A loaded value of zero stands for a span of 65536.

Top module: `interval_counter_chan`

## Requirements
- R1: A load of 0 means a span of 65536. In mode 0, `out_level` rises only after 65536 ticks. In mode 3, the count starts at 65536 and steps down by two from there (shown as 0x0000, then 0xFFFE).
- R2: A load writes the value to `count_out` on the next cycle. It sets `out_level` to the load level: low for modes 0 and 1, high for all other modes. A load discards any tick that arrives in the same cycle.
- R3: In modes 0, 1, 4 and 5, each effective tick decrements the count by one. From 0 the count wraps to 0xFFFF, and it never reloads.
- R4: In mode 3, each effective tick subtracts two while the count is above 2. At 2 or below, the tick reloads the initial span and toggles `out_level`.
- R5: In mode 2, a tick at count 1 reloads the initial span. A tick at any other count decrements by one. `out_level` is low exactly while the count reads 1 after a tick.
- R6: In modes 1, 2, 3 and 5, the gate is sampled by one register, and a rising edge is detected against the previous sample. The edge reloads the initial span and restores the load level on the clock edge after the sampled rise, so two cycles after `gate` rises. This reload takes priority over a tick in the same cycle.
- R7: In modes 0 and 4, a sampled gate low freezes the count. A gate rising edge does not reload the count.
- R8: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R9: In modes 0 and 1, `out_level` goes high on the tick that moves the count from 1 to 0. It then stays high through the wrap until the next load or retrigger.
- R10: In modes 4 and 5, `out_level` is low for exactly one tick period after the count reaches 0, and high otherwise.
- R11: After a mode write, ticks and gate edges have no effect until a count is loaded. A mode write and a load in the same cycle start counting in the new mode.
- R12: After reset, the channel is in mode 0 and waiting for a load, with `count_out` at 0 and `out_level` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counting clock enable, one tick per asserted cycle |
| gate | input | 1 | Gate input, edge or level meaning depends on mode |
| mode_wr | input | 1 | Mode program strobe |
| mode_code | input | 3 | Mode code, 0 to 7 |
| load_wr | input | 1 | Initial-count load strobe |
| load_val | input | 16 | Initial count, 0 means 65536 |
| count_out | output | 16 | Live count |
| out_level | output | 1 | Channel output level |

## Verification
A count load or a gate retrigger can fall in the same cycle as a counting tick. The bench holds `tick_en` high through every load, and it raises `gate` while ticks continue in modes 1, 2, 3 and 5. In each such cycle, the reload must win and the tick must be lost. A mode write can also coincide with a load. The bench issues both in one cycle and expects counting to start in the new mode. A behavioural model judges all of these cases, comparing count and level on every clock.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [2:0] {
        M_INT_TC    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_e;

    typedef enum logic {
        ST_ARMED    = 1'b0,
        ST_COUNTING = 1'b1
    } phase_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic mode_e decode_mode(input logic [2:0] code);
        mode_e m;
        unique case (code)
            3'd6:    m = M_RATE;
            3'd7:    m = M_SQUARE;
            default: m = mode_e'(code);
        endcase
        return m;
    endfunction

    function automatic logic gate_restarts(input mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
    endfunction

    function automatic logic gate_enables(input mode_e m);
        return (m == M_INT_TC) || (m == M_SW_STROBE);
    endfunction

    function automatic logic load_level(input mode_e m);
        return !((m == M_INT_TC) || (m == M_ONESHOT));
    endfunction

endpackage

// File: rtl/ictr_gate_sampler.sv
module ictr_gate_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic gate_lvl,
    output logic gate_rise
);
    logic now_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            now_q  <= gate_in;
            prev_q <= now_q;
        end
    end

    assign gate_lvl  = now_q;
    assign gate_rise = now_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_rise |=> !gate_rise);  // R6

endmodule

// File: rtl/ictr_count_stepper.sv
module ictr_count_stepper
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  mode_e         mode,
    input  logic [CW:0]   cnt,
    input  logic [CW:0]   init,
    input  logic          out_cur,
    output logic [CW:0]   cnt_nxt,
    output logic          out_nxt
);
    localparam int IW = CW + 1;

    logic [IW-1:0] wrapped;
    logic          terminal;
    logic          sq_expire;

    assign wrapped   = {1'b0, cnt[CW-1:0] - 1'b1};
    assign terminal  = (cnt == IW'(1));
    assign sq_expire = (cnt <= IW'(2));

    always_comb begin
        cnt_nxt = cnt;
        out_nxt = out_cur;
        unique case (mode)
            M_INT_TC, M_ONESHOT: begin
                cnt_nxt = wrapped;
                out_nxt = out_cur | terminal;
            end
            M_SW_STROBE, M_HW_STROBE: begin
                cnt_nxt = wrapped;
                out_nxt = !terminal;
            end
            M_RATE: begin
                cnt_nxt = terminal ? init : (cnt - IW'(1));
                out_nxt = (cnt_nxt[CW-1:0] != CW'(1));
            end
            M_SQUARE: begin
                cnt_nxt = sq_expire ? init : (cnt - IW'(2));
                out_nxt = sq_expire ? !out_cur : out_cur;
            end
            default: begin
                cnt_nxt = cnt;
                out_nxt = out_cur;
            end
        endcase
    end

endmodule

// File: rtl/interval_counter_chan.sv
module interval_counter_chan
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          gate,
    input  logic          mode_wr,
    input  logic [2:0]    mode_code,
    input  logic          load_wr,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count_out,
    output logic          out_level
);
    localparam int            IW        = CW + 1;
    localparam logic [IW-1:0] FULL_SPAN = IW'(1) << CW;

    phase_e        phase_q, phase_d;
    mode_e         mode_q;
    mode_e         new_mode;
    logic [IW-1:0] cnt_q, init_q, cnt_nxt, load_span;
    logic          out_q, out_nxt;
    logic          gate_lvl, gate_rise;
    logic          running, retrig, advance;

    ictr_gate_sampler i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_in   (gate),
        .gate_lvl  (gate_lvl),
        .gate_rise (gate_rise)
    );

    ictr_count_stepper #(.CW(CW)) i_step (
        .mode    (mode_q),
        .cnt     (cnt_q),
        .init    (init_q),
        .out_cur (out_q),
        .cnt_nxt (cnt_nxt),
        .out_nxt (out_nxt)
    );

    assign new_mode  = decode_mode(mode_code);
    assign load_span = (load_val == '0) ? FULL_SPAN : {1'b0, load_val};
    assign running   = (phase_q == ST_COUNTING);
    assign retrig    = running & gate_rise & gate_restarts(mode_q);
    assign advance   = running & tick_en & (gate_lvl | ~gate_enables(mode_q));

    // next state: ARM_TO_COUNT, COUNT_TO_ARM, otherwise STAY
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_ARMED:    if (load_wr) phase_d = ST_COUNTING;
            ST_COUNTING: if (mode_wr && !load_wr) phase_d = ST_ARMED;
            default:     phase_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= ST_ARMED;
        else        phase_q <= phase_d;
    end

    // mode, span and live count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_INT_TC;
            init_q <= FULL_SPAN;
            cnt_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= new_mode;
            if (load_wr) begin
                init_q <= load_span;
                cnt_q  <= load_span;
            end else if (!mode_wr) begin
                if (retrig)       cnt_q <= init_q;
                else if (advance) cnt_q <= cnt_nxt;
            end
        end
    end

    // output level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (mode_wr) begin
            out_q <= load_level(new_mode);
        end else if (load_wr || retrig) begin
            out_q <= load_level(mode_q);
        end else if (advance) begin
            out_q <= out_nxt;
        end
    end

    assign count_out = cnt_q[CW-1:0];
    assign out_level = out_q;

    AST_ZERO_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr && (load_val == '0) |=> init_q == FULL_SPAN);  // R1
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count_out == $past(load_val)) && (phase_q == ST_COUNTING));  // R2
    AST_WRAP_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !retrig && !load_wr && !mode_wr && (cnt_q == '0) &&
        (mode_q inside {M_INT_TC, M_ONESHOT, M_SW_STROBE, M_HW_STROBE})
        |=> count_out == '1);  // R3
    AST_SQUARE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !retrig && !load_wr && !mode_wr && (mode_q == M_SQUARE) && (cnt_q > IW'(2))
        |=> cnt_q == $past(cnt_q) - IW'(2));  // R4
    AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !retrig && !load_wr && !mode_wr && (mode_q == M_RATE) && (cnt_q == IW'(1))
        |=> cnt_q == init_q);  // R5
    AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        retrig && !load_wr && !mode_wr |=> (cnt_q == init_q) && (out_q == load_level(mode_q)));  // R6
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        running && gate_enables(mode_q) && !gate_lvl && !load_wr && !mode_wr |=> $stable(cnt_q));  // R7
    AST_ALIAS_SIX: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && (mode_code == 3'd6) |=> mode_q == M_RATE);  // R8
    AST_TC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !retrig && !load_wr && !mode_wr && (cnt_q == IW'(1)) &&
        (mode_q inside {M_INT_TC, M_ONESHOT}) |=> out_q);  // R9
    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running && !out_q && (mode_q inside {M_SW_STROBE, M_HW_STROBE}) |-> count_out == '0);  // R10
    AST_ARMED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_ARMED) && !load_wr |=> $stable(cnt_q));  // R11

endmodule

// File: tb/test_interval_counter_chan.sv
`timescale 1ns/1ps
module test_interval_counter_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        gate = 1'b0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_code = 3'd0;
    logic        load_wr = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count_out;
    logic        out_level;

    always #2 clk = ~clk;

    interval_counter_chan i_interval_counter_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .gate      (gate),
        .mode_wr   (mode_wr),
        .mode_code (mode_code),
        .load_wr   (load_wr),
        .load_val  (load_val),
        .count_out (count_out),
        .out_level (out_level)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    wd    = 0;
    string cur_req = "R12";

    // behavioural reference state
    int m_mode = 0, m_init = 65536, m_cnt = 0, m_out = 0, m_run = 0;
    int g_hist[$] = '{0, 0};   // [0] newest sample, [1] previous

    function automatic int dec(input int c);
        return (c == 6) ? 2 : (c == 7) ? 3 : c;
    endfunction

    function automatic int lvl_of(input int m);
        return (m <= 1) ? 0 : 1;
    endfunction

    task automatic model_step();
        int rise, lvl_ok, span;
        rise   = (g_hist[0] == 1) && (g_hist[1] == 0);
        lvl_ok = (m_mode == 0 || m_mode == 4) ? g_hist[0] : 1;
        span   = (load_val == 0) ? 65536 : int'(load_val);
        if (mode_wr) begin
            m_mode = dec(int'(mode_code));
            m_out  = lvl_of(m_mode);
            if (load_wr) begin m_init = span; m_cnt = span; m_run = 1; end
            else m_run = 0;
        end else if (load_wr) begin
            m_init = span; m_cnt = span; m_run = 1; m_out = lvl_of(m_mode);
        end else if (m_run == 1) begin
            if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
                m_cnt = m_init; m_out = lvl_of(m_mode);
            end else if (tick_en && lvl_ok) begin
                case (m_mode)
                    0, 1: begin if (m_cnt == 1) m_out = 1; m_cnt = (m_cnt - 1) & 65535; end
                    4, 5: begin m_out = (m_cnt != 1); m_cnt = (m_cnt - 1) & 65535; end
                    2: begin
                        m_cnt = (m_cnt == 1) ? m_init : m_cnt - 1;
                        m_out = ((m_cnt & 65535) != 1);
                    end
                    default: begin
                        if (m_cnt <= 2) begin m_cnt = m_init; m_out = 1 - m_out; end
                        else m_cnt = m_cnt - 2;
                    end
                endcase
            end
        end
        void'(g_hist.pop_back());
        g_hist.push_front(int'(gate));
    endtask

    task automatic check_outputs();
        n_cmp++;
        if (count_out !== 16'(m_cnt) || out_level !== (m_out != 0)) begin
            n_bad++;
            $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                     cur_req, count_out, out_level, 16'(m_cnt), (m_out != 0));
        end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
        mode_wr = 1'b0;
        load_wr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic prog(input int code);
        mode_code = 3'(code); mode_wr = 1'b1; cycle();
    endtask

    task automatic ld(input int v);
        load_val = 16'(v); load_wr = 1'b1; cycle();
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R12"; check_outputs();

        // R11: armed channel ignores ticks and gate
        cur_req = "R11"; tick_en = 1'b1; gate = 1'b1; run(3);
        gate = 1'b0; run(2); gate = 1'b1; run(3);
        prog(2); run(4);

        // R9 and R3: mode 0 through terminal count and wrap
        cur_req = "R9"; prog(0); ld(5); run(9);
        cur_req = "R3"; prog(1); ld(2); run(5);
        prog(5); ld(3); run(6);

        // R10: software strobe
        cur_req = "R10"; prog(4); ld(4); run(8);

        // R7: level gating in modes 0 and 4
        cur_req = "R7"; prog(0); ld(10); run(2);
        gate = 1'b0; run(4); gate = 1'b1; run(4);
        prog(4); ld(6); run(1); gate = 1'b0; run(3); gate = 1'b1; run(5);

        // R5: rate generator with uneven ticks
        cur_req = "R5"; prog(2); ld(4);
        for (int i = 0; i < 14; i++) begin tick_en = 1'(i % 2); cycle(); end
        tick_en = 1'b1; run(10);

        // R6: gate retrigger in modes 2, 5, 1, 3
        cur_req = "R6"; gate = 1'b0; run(2); gate = 1'b1; run(4);
        prog(5); ld(6); run(3); gate = 1'b0; run(1); gate = 1'b1; run(8);
        prog(1); ld(4); run(2); gate = 1'b0; run(2); gate = 1'b1; run(7);
        prog(3); ld(8); run(3); gate = 1'b0; run(1); gate = 1'b1; run(6);

        // R4: square wave, odd and even spans
        cur_req = "R4"; prog(3); ld(7); run(12); ld(6); run(10);
        tick_en = 1'b0; run(2); tick_en = 1'b1; run(4);

        // R8: aliased codes
        cur_req = "R8"; prog(6); ld(3); run(8); prog(7); ld(5); run(8);

        // R2: load mid-count, load with a tick in the same cycle
        cur_req = "R2"; prog(0); ld(9); run(3); ld(2); run(4);
        prog(2); ld(5); run(2); ld(3); run(5);

        // R11: mode write and load in one cycle
        cur_req = "R11"; mode_code = 3'd3; mode_wr = 1'b1; load_val = 16'd4; load_wr = 1'b1;
        cycle(); run(6);

        // R1: zero load spans 65536
        cur_req = "R1"; prog(3); ld(0); run(40);
        prog(0); ld(0); run(65540);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule